// File: doc/BRIEF.md
# Audio Sample Ingest Formatter

This block sits between a 32-bit common data port and a transmit line encoder. Each word written to the port holds one or two audio samples in a container of one to four bytes. The block unpacks the container using the configured byte order and justification. It aligns each sample to a signed 24-bit value with the sign bit on top. It then assigns samples to channel 1 (left) and channel 2 (right), and places complete left/right frames in a small queue that the encoder drains.

A static mode word sets the behaviour:

- the channel count;
- the byte order;
- the justification;
- the channel access mode;
- the valid bit count;
- the container size;
- a chunk threshold.

A control strobe can flush the queue or soft-reset the whole block. A status vector reports the queue level, per-channel readiness and sticky error flags.

Both data interfaces are valid/ready:

- **Input side.** `in_ready` is high whenever the queue has room. The writer is a register port that cannot stall, so a word presented while `in_ready` is low is dropped and recorded as an overrun.
- **Output side.** `out_valid` is high whenever a frame is queued. The encoder runs at a fixed rate, so `out_ready` asserted while `out_valid` is low is recorded as an underrun. No frame moves in that case.

Top module: `pcm_ingest_formatter`

## Requirements
- R1: After `rst_n` is released, the status reads 0x30B when the chunk field is at most DEPTH. In that state `out_valid` is 0 and `in_ready` is 1.
- R2: Mode bit 2 sets the byte order inside a container. With 0, the lowest-addressed byte (word bits 7:0 upward) is the least significant. With 1, it is the most significant.
- R3: Mode bit 3 sets justification. With 0, the valid bits are the low end of the container; with 1, they are the high end. The output holds the valid field left-aligned in 24 bits with zero fill below. When more than 24 bits are valid, only the top 24 are kept.
- R4: Mode bits 29:28 hold the container size in bytes minus one. Mode bits 13:8 hold the valid bit count. Counts of 8, 16, 18, 20, 24 and 32 are supported, each no larger than the container.
- R5: With mode bit 1 at 0 (mono), each accepted word makes one frame, and its sample is copied to both channels.
- R6: In dual mode with access field (bits 5:4) equal to 0, `in_chan` picks the channel: 0 is channel 1, 1 is channel 2. A second write to an already-filled channel replaces that sample. A frame is queued once both channels hold a sample.
- R7: In dual mode with access field 1 (or 3), consecutive accepted words alternate between channel 1 and channel 2, starting with channel 1. `in_chan` is ignored. The alternation restarts at channel 1 after a flush or reset.
- R8: In dual mode with access field 2 and a container of one or two bytes, one word holds both samples. The lowest-addressed container goes to channel 1 and the next one to channel 2. With a larger container, access field 2 behaves as in R7.
- R9: Frames leave in the order they were completed. Status bits have these meanings:
  - bit 0: ready (`in_ready`);
  - bit 1: empty;
  - bit 2: full;
  - bits 8 and 9: channel 1 and channel 2 ready, meaning that channel's slot is free and the queue is not full.
- R10: A word presented while the queue is full is discarded and sets sticky overrun status bit 5. The queued frames are left unchanged.
- R11: `out_ready` with an empty queue sets sticky underrun bit 4. It also sets sticky bit 11 (channel 1) and/or bit 12 (channel 2) for each channel whose slot held no sample in that cycle.
- R12: Status bit 3 is high when the number of free queue entries is at least the chunk field (mode bits 19:16).
- R13: A control strobe with bit 1 flushes the queue and the channel slots and resets the alternation, but keeps the sticky flags. A strobe with bit 0 does all of that and also clears the sticky flags. In a cycle with either strobe, the data input and the pop request are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | 32 | Static configuration word (fields in R2 to R8, R12) |
| ctl_valid | input | 1 | Control strobe |
| ctl_cmd | input | 2 | Bit 0 soft reset, bit 1 flush |
| in_valid | input | 1 | Data word present |
| in_ready | output | 1 | Queue can accept a word |
| in_data | input | 32 | Written data word |
| in_chan | input | 1 | Target channel in indexed access |
| out_valid | output | 1 | A frame is available |
| out_ready | input | 1 | Encoder takes the head frame |
| out_left | output | 24 | Channel 1 sample of the head frame |
| out_right | output | 24 | Channel 2 sample of the head frame |
| status | output | 13 | Status vector (R9 to R12) |

## Verification
The bench covers these corners, with the failure each one would reveal:

- **Container extraction.** Samples are taken from one-, two-, three- and four-byte containers in both byte orders. A swapped byte index or a wrong shift shows up as scrambled or shifted output.
- **Alignment.** It covers 32 valid bits trimmed to 24, 8 valid bits zero-filled, and 18 bits under the low-end justification. A wrong shift amount would lose the sign bit or leave junk in the low bits.
- **Channel steering.** It checks a same-channel rewrite in indexed mode, two samples per word in interleaved mode, and interleaved mode with a three-byte container. A steering fault swaps channels or pushes half-empty frames.
- **Queue edges.** It fills the queue to full and writes into it, and drains it while empty with one channel staged. It also issues a flush followed by a soft reset. These catch a lost or corrupted frame, an overrun or underrun flag that is not sticky, and an alternation pointer that is not restarted.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_N   = WORD_W / 8;
  localparam int SAMPLE_W = 24;
  localparam int LANES    = 2;
  localparam int FRAME_W  = LANES * SAMPLE_W;
  localparam int STAT_W   = 13;

  // status bit positions
  localparam int ST_READY   = 0;
  localparam int ST_EMPTY   = 1;
  localparam int ST_FULL    = 2;
  localparam int ST_CHUNK   = 3;
  localparam int ST_UNDER   = 4;
  localparam int ST_OVER    = 5;
  localparam int ST_CH_RDY  = 8;   // +0 channel 1, +1 channel 2
  localparam int ST_CH_UND  = 11;  // +0 channel 1, +1 channel 2

  typedef enum logic [1:0] {
    ACC_INDEXED = 2'd0,
    ACC_TOGGLE  = 2'd1,
    ACC_PAIRED  = 2'd2,
    ACC_SPARE   = 2'd3
  } acc_e;

  typedef struct packed {
    logic       dual;
    logic       big;
    logic       msb_just;
    acc_e       acc;
    logic [5:0] vbits;
    logic [3:0] chunk;
    logic [1:0] cbytes_m1;
  } mode_t;
endpackage

// File: rtl/fmt_lane.sv
module fmt_lane
  import fmt_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic [WORD_W-1:0]   word,
  input  mode_t               mode,
  output logic [SAMPLE_W-1:0] sample
);
  localparam logic [WORD_W-1:0] ONES = '1;

  logic [2:0]        cbytes;
  logic [5:0]        cbits;
  logic [5:0]        start_bits;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] reversed;
  logic [WORD_W-1:0] raw;
  logic [WORD_W-1:0] aligned;

  always_comb begin
    cbytes     = {1'b0, mode.cbytes_m1} + 3'd1;
    cbits      = {cbytes, 3'b000};
    start_bits = (LANE == 0) ? 6'd0 : cbits;
    shifted    = word >> start_bits;
    for (int i = 0; i < BYTE_N; i++) begin
      reversed[8*(BYTE_N-1-i) +: 8] = shifted[8*i +: 8];
    end
    if (mode.big) raw = reversed >> (6'd32 - cbits);
    else          raw = shifted & (ONES >> (6'd32 - cbits));
    if (mode.msb_just)
      aligned = (raw << (6'd32 - cbits)) & ~(ONES >> mode.vbits);
    else
      aligned = raw << (6'd32 - mode.vbits);
    sample = aligned[WORD_W-1 -: SAMPLE_W];
  end
endmodule

// File: rtl/fmt_frame_queue.sv
module fmt_frame_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign dout  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_fill_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> !empty);
endmodule

// File: rtl/pcm_ingest_formatter.sv
module pcm_ingest_formatter
  import fmt_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   mode_word,
  input  logic                ctl_valid,
  input  logic [1:0]          ctl_cmd,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_data,
  input  logic                in_chan,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic [STAT_W-1:0]   status
);
  localparam int CW = $clog2(DEPTH+1);

  mode_t m;
  logic  mode_unused;
  assign m.dual      = mode_word[1];
  assign m.big       = mode_word[2];
  assign m.msb_just  = mode_word[3];
  assign m.acc       = acc_e'(mode_word[5:4]);
  assign m.vbits     = mode_word[13:8];
  assign m.chunk     = mode_word[19:16];
  assign m.cbytes_m1 = mode_word[29:28];
  assign mode_unused = ^{mode_word[31:30], mode_word[27:20], mode_word[15:14],
                         mode_word[7:6], mode_word[0]};

  logic [SAMPLE_W-1:0] lane_s [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fmt_lane #(.LANE(g)) u_lane (.word(in_data), .mode(m), .sample(lane_s[g]));
  end

  logic do_reset, do_clear;
  assign do_reset = ctl_valid && ctl_cmd[0];
  assign do_clear = ctl_valid && (ctl_cmd[0] || ctl_cmd[1]);

  logic          q_full, q_empty, q_push, q_pop;
  logic [CW-1:0] q_count;
  logic [FRAME_W-1:0] q_din, q_dout;

  logic [LANES-1:0]                slot_full, wr_mask, filled;
  logic [LANES-1:0][SAMPLE_W-1:0]  slot_d, wr_d, merged;
  logic tog, two_per_word, alternating, accept, starve;
  logic ovr, und;
  logic [LANES-1:0] ch_und;

  assign in_ready     = !q_full;
  assign accept       = in_valid && !q_full && !do_clear;
  assign two_per_word = m.dual && (m.acc == ACC_PAIRED) && (m.cbytes_m1 <= 2'd1);
  assign alternating  = m.dual && !two_per_word && (m.acc != ACC_INDEXED);

  // channel steering
  always_comb begin
    wr_d[0] = lane_s[0];
    wr_d[1] = two_per_word ? lane_s[1] : lane_s[0];
    if (!m.dual || two_per_word)   wr_mask = 2'b11;
    else if (m.acc == ACC_INDEXED) wr_mask = in_chan ? 2'b10 : 2'b01;
    else                           wr_mask = tog ? 2'b10 : 2'b01;
    for (int c = 0; c < LANES; c++) begin
      merged[c] = wr_mask[c] ? wr_d[c] : slot_d[c];
    end
    filled = slot_full | wr_mask;
  end

  assign q_push = accept && (&filled);
  assign q_din  = {merged[0], merged[1]};
  assign q_pop  = out_ready && !q_empty && !do_clear;
  assign starve = out_ready && q_empty && !do_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_full <= '0;
      slot_d    <= '0;
      tog       <= 1'b0;
    end else if (do_clear) begin
      slot_full <= '0;
      tog       <= 1'b0;
    end else if (accept) begin
      slot_full <= q_push ? '0 : filled;
      for (int c = 0; c < LANES; c++) begin
        if (wr_mask[c]) slot_d[c] <= wr_d[c];
      end
      if (alternating) tog <= ~tog;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr    <= 1'b0;
      und    <= 1'b0;
      ch_und <= '0;
    end else if (do_reset) begin
      ovr    <= 1'b0;
      und    <= 1'b0;
      ch_und <= '0;
    end else begin
      if (in_valid && q_full && !do_clear) ovr <= 1'b1;
      if (starve) begin
        und    <= 1'b1;
        ch_und <= ch_und | ~slot_full;
      end
    end
  end

  fmt_frame_queue #(.DEPTH(DEPTH), .W(FRAME_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(do_clear),
    .push(q_push), .din(q_din), .pop(q_pop), .dout(q_dout),
    .full(q_full), .empty(q_empty), .count(q_count));

  assign out_valid = !q_empty;
  assign out_left  = q_dout[FRAME_W-1 -: SAMPLE_W];
  assign out_right = q_dout[SAMPLE_W-1:0];

  always_comb begin
    status = '0;
    status[ST_READY] = !q_full;
    status[ST_EMPTY] = q_empty;
    status[ST_FULL]  = q_full;
    status[ST_CHUNK] = (DEPTH - int'(q_count)) >= int'(m.chunk);
    status[ST_UNDER] = und;
    status[ST_OVER]  = ovr;
    for (int c = 0; c < LANES; c++) begin
      status[ST_CH_RDY+c] = !slot_full[c] && !q_full;
      status[ST_CH_UND+c] = ch_und[c];
    end
  end

  assert_overrun_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !ctl_valid) |=> status[ST_OVER]);
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_OVER] && !(ctl_valid && ctl_cmd[0])) |=> status[ST_OVER]);
  assert_underrun_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid && !ctl_valid) |=> status[ST_UNDER]);
  assert_flush_empties_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && (ctl_cmd != 2'b00)) |=> (!out_valid && status[ST_EMPTY]));
  assert_mono_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_word[1] && $stable(mode_word) && out_valid && $past(q_empty) && !$past(do_clear))
      |-> (out_left == out_right));
endmodule

// File: tb/tb_pcm_ingest_formatter.sv
`timescale 1ns/1ps
module tb_pcm_ingest_formatter;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mode_w = 32'h0001_1801;
  logic        ctl_valid = 1'b0;
  logic [1:0]  ctl_cmd = 2'b00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_chan = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_left, out_right;
  logic [12:0] status;

  always #2.5 clk = ~clk;

  pcm_ingest_formatter #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_w), .ctl_valid(ctl_valid),
    .ctl_cmd(ctl_cmd), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chan(in_chan), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right),
    .status(status));

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string req = "R1";

  // reference model state
  logic [47:0] mq[$];
  bit          sf[2];
  logic [23:0] sd[2];
  bit          tg, m_ovr, m_und;
  bit          m_cu[2];

  function automatic logic [23:0] ref_sample(input logic [31:0] w, input bit big,
      input bit msbj, input int v, input int c, input int k);
    longint raw, field, res;
    raw = 0;
    for (int i = 0; i < c; i++) begin
      longint b;
      b = (longint'(w) >> (8*(k*c+i))) & 255;
      if (big) raw = raw*256 + b;
      else     raw = raw + (b << (8*i));
    end
    if (msbj) field = raw >> (8*c - v);
    else      field = raw & ((64'd1 << v) - 1);
    if (v >= 24) res = field >> (v-24);
    else         res = field << (24-v);
    return res[23:0];
  endfunction

  task automatic model_wipe(input bit all);
    mq.delete();
    sf[0] = 0; sf[1] = 0; tg = 0;
    if (all) begin m_ovr = 0; m_und = 0; m_cu[0] = 0; m_cu[1] = 0; end
  endtask

  task automatic model_update();
    bit dual, big, msbj, paired;
    int v, c, acc, ch;
    logic [23:0] s0, s1;
    bit was_full;
    if (!rst_n || (ctl_valid && ctl_cmd[0])) begin model_wipe(1); return; end
    if (ctl_valid && ctl_cmd[1]) begin model_wipe(0); return; end
    dual = mode_w[1]; big = mode_w[2]; msbj = mode_w[3];
    acc = int'(mode_w[5:4]); v = int'(mode_w[13:8]); c = int'(mode_w[29:28]) + 1;
    was_full = (mq.size() == DEPTH);
    if (out_ready) begin
      if (mq.size() == 0) begin
        m_und = 1;
        if (!sf[0]) m_cu[0] = 1;
        if (!sf[1]) m_cu[1] = 1;
      end else void'(mq.pop_front());
    end
    if (in_valid) begin
      if (was_full) m_ovr = 1;
      else begin
        s0 = ref_sample(in_data, big, msbj, v, c, 0);
        s1 = ref_sample(in_data, big, msbj, v, c, 1);
        paired = dual && acc == 2 && c <= 2;
        if (!dual) mq.push_back({s0, s0});
        else if (paired) begin
          mq.push_back({s0, s1}); sf[0] = 0; sf[1] = 0;
        end else begin
          ch = (acc == 0) ? int'(in_chan) : int'(tg);
          if (acc != 0) tg = ~tg;
          sd[ch] = s0; sf[ch] = 1;
          if (sf[0] && sf[1]) begin
            mq.push_back({sd[0], sd[1]}); sf[0] = 0; sf[1] = 0;
          end
        end
      end
    end
  endtask

  function automatic logic [12:0] model_status();
    logic [12:0] s;
    bit full;
    full = (mq.size() == DEPTH);
    s = '0;
    s[0] = !full; s[1] = (mq.size() == 0); s[2] = full;
    s[3] = (DEPTH - mq.size()) >= int'(mode_w[19:16]);
    s[4] = m_und; s[5] = m_ovr;
    s[8] = !sf[0] && !full; s[9] = !sf[1] && !full;
    s[11] = m_cu[0]; s[12] = m_cu[1];
    return s;
  endfunction

  task automatic chk(input string r, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic compare();
    chk({req, " status"}, {35'd0, status}, {35'd0, model_status()});
    chk({req, " handshake"}, {46'd0, in_ready, out_valid},
        {46'd0, mq.size() != DEPTH, mq.size() != 0});
    if (mq.size() != 0) chk({req, " frame"}, {out_left, out_right}, mq[0]);
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic set_mode(input bit dual, input bit big, input bit msbj, input int acc,
                          input int vb, input int chunk, input int cb);
    mode_w = (32'(cb-1) << 28) | (32'(chunk) << 16) | (32'(vb) << 8) | (32'(acc) << 4)
           | (32'(msbj) << 3) | (32'(big) << 2) | (32'(dual) << 1) | 32'd1;
  endtask

  task automatic put(input logic [31:0] w, input bit ch);
    in_valid = 1; in_data = w; in_chan = ch;
    step();
    in_valid = 0;
  endtask

  task automatic drain(input int n);
    out_ready = 1;
    repeat (n) step();
    out_ready = 0;
  endtask

  task automatic control(input logic [1:0] cmd);
    ctl_valid = 1; ctl_cmd = cmd;
    step();
    ctl_valid = 0; ctl_cmd = 2'b00;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    model_wipe(1);
    repeat (3) step();
    rst_n = 1;
    step();
    req = "R1";
    chk("R1 reset status", {35'd0, status}, 48'h30B);
    chk("R1 reset handshake", {46'd0, in_ready, out_valid}, 48'd2);

    // R5 mono copy, R2 byte order with 3-byte container
    req = "R2";
    set_mode(0, 1, 0, 1, 24, 1, 3);
    put(32'h00AB_CDEF, 1);
    chk("R2 big endian", {out_left, out_right}, {24'hEFCDAB, 24'hEFCDAB});
    drain(1);
    req = "R5";
    set_mode(0, 0, 0, 1, 24, 1, 3);
    put(32'h00AB_CDEF, 0);
    chk("R5 mono copy little", {out_left, out_right}, {24'hABCDEF, 24'hABCDEF});
    drain(1);

    // R3 justification and alignment, R4 container/valid sizes
    req = "R3";
    set_mode(0, 0, 1, 1, 20, 1, 4);
    put(32'h1234_5678, 0);
    chk("R3 msb 20 bit", {24'd0, out_left}, {24'd0, 24'h123450});
    drain(1);
    set_mode(0, 0, 1, 1, 32, 1, 4);
    put(32'h1234_5678, 0);
    chk("R3 32 bit trim", {24'd0, out_left}, {24'd0, 24'h123456});
    drain(1);
    req = "R4";
    set_mode(0, 0, 0, 1, 8, 1, 1);
    put(32'hFFFF_FF9C, 0);
    chk("R4 8 bit container", {24'd0, out_left}, {24'd0, 24'h9C0000});
    drain(1);
    set_mode(0, 0, 0, 1, 18, 1, 3);
    put(32'hFF03_FFFF, 0);
    chk("R4 18 bit lsb", {24'd0, out_left}, {24'd0, 24'hFFFFC0});
    drain(1);

    // R7 toggle
    req = "R7";
    set_mode(1, 0, 0, 1, 16, 1, 2);
    put(32'h0000_1111, 1);
    chk("R7 half frame", {35'd0, out_valid, status[9:8], 10'd0}, {35'd0, 1'b0, 2'b10, 10'd0});
    put(32'h0000_2222, 0);
    chk("R7 toggle frame", {out_left, out_right}, {24'h111100, 24'h222200});
    drain(1);

    // R6 indexed with overwrite
    req = "R6";
    set_mode(1, 0, 0, 0, 16, 1, 2);
    put(32'h0000_AAAA, 1);
    put(32'h0000_BBBB, 1);
    chk("R6 no frame yet", {47'd0, out_valid}, 48'd0);
    put(32'h0000_CCCC, 0);
    chk("R6 indexed frame", {out_left, out_right}, {24'hCCCC00, 24'hBBBB00});
    drain(1);

    // R8 paired access
    req = "R8";
    set_mode(1, 0, 0, 2, 16, 1, 2);
    put(32'h5555_3333, 0);
    chk("R8 paired 16", {out_left, out_right}, {24'h333300, 24'h555500});
    drain(1);
    set_mode(1, 0, 0, 2, 8, 1, 1);
    put(32'h0000_7F80, 0);
    chk("R8 paired 8", {out_left, out_right}, {24'h800000, 24'h7F0000});
    drain(1);
    set_mode(1, 0, 0, 2, 24, 1, 3);
    put(32'h0012_3456, 1);
    put(32'h00AB_CDEF, 1);
    chk("R8 wide falls back", {out_left, out_right}, {24'h123456, 24'hABCDEF});
    drain(1);

    // R12 chunk and R10 overrun
    req = "R12";
    set_mode(0, 0, 0, 1, 16, 4, 2);
    for (int i = 0; i < 4; i++) put(32'h100 + 32'(i), 0);
    chk("R12 chunk at 4 free", {47'd0, status[3]}, 48'd1);
    put(32'h0000_0104, 0);
    chk("R12 chunk at 3 free", {47'd0, status[3]}, 48'd0);
    req = "R10";
    for (int i = 5; i < 8; i++) put(32'h100 + 32'(i), 0);
    chk("R10 full", {45'd0, status[2], status[0], in_ready}, {45'd0, 3'b100});
    put(32'h0000_DEAD, 0);
    chk("R10 overrun flag", {47'd0, status[5]}, 48'd1);
    chk("R10 head kept", {24'd0, out_left}, {24'd0, 24'h010000});
    req = "R9";
    drain(8);

    // R11 underrun with channel 1 staged
    req = "R11";
    control(2'b01);
    set_mode(1, 0, 0, 1, 16, 1, 2);
    put(32'h0000_1234, 0);
    drain(1);
    chk("R11 underrun bits", {35'd0, status[12], status[11], 6'd0, status[4], 4'd0},
        {35'd0, 2'b10, 6'd0, 1'b1, 4'd0});

    // R13 flush keeps sticky, restarts toggle; soft reset clears sticky
    req = "R13";
    control(2'b10);
    chk("R13 flush keeps sticky", {46'd0, status[4], status[1]}, 48'd3);
    put(32'h0000_1234, 1);
    chk("R13 toggle restart", {46'd0, status[9:8]}, 48'd2);
    put(32'h0000_5678, 0);
    chk("R13 frame after flush", {out_left, out_right}, {24'h123400, 24'h567800});
    control(2'b01);
    chk("R13 soft reset", {35'd0, status}, 48'h30B);

    // R9 streaming with concurrent push and pop
    req = "R9";
    set_mode(0, 1, 0, 1, 16, 2, 2);
    lf = 32'hACE1_1234;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      in_valid = lf[3] | lf[5];
      in_data = lf;
      out_ready = lf[7];
      step();
    end
    in_valid = 0;
    drain(DEPTH + 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule